// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Management Bus

This block is the target side of a two-wire management bus (SMBus-style timing). It gives a host read and write access to a small bank of 8-bit control registers. The block samples the raw clock and data lines. It filters them, finds start, repeated-start and stop conditions, and answers to one fixed device address. The register contents are always present on a wide parallel output, so the rest of the chip can use them as static configuration.

Every transfer moves a block of bytes through an index pointer. To write, the host sends a starting index, a byte count and then that many data bytes. To read, the host first sets the index in a short write. It then issues a repeated start with the read address. The slave answers with a count byte, taken from a count register the host can program, and then sends register bytes starting at the index. The slave pulls the data line low to acknowledge and to send zeros, and releases it otherwise.

Top module: `smbr_blk_slave`

## Requirements
- R1: The 8-bit address byte 0xDC (device 7'h6E, direction bit 0) opens a write and 0xDD (direction bit 1) opens a read, and both are acknowledged. Any other address byte is not acknowledged, and every byte that follows is also left unacknowledged, with no register changed, until the next start.
- R2: In a write, the first byte after the address is the starting index N and the second is the byte count X. Each of these two bytes is acknowledged, and so is each of the X data bytes. The data bytes land in registers N, N+1, ... in the order they arrive.
- R3: A data byte that arrives after the X counted bytes is not acknowledged and is not stored, and the slave ignores the bus until the next start.
- R4: The index advances by one after each byte stored or sent, and wraps from 15 to 0.
- R5: After a repeated start with 0xDD, the slave first sends the value held in register 8, then the registers from index N upward. Each byte is sent MSB first.
- R6: When the host does not acknowledge a read byte, the slave releases the data line and drives nothing more until the next start.
- R7: After reset the data line is released, register 8 holds 0x08 and every other register holds 0x00.
- R8: A stop seen at any bit position ends the transfer and returns to idle, where bytes are not acknowledged. A start seen at any bit position abandons the partial byte and begins a new address reception.
- R9: The slave changes its data-line drive only while the filtered clock is low. During the eight data bits of a byte it receives, it does not drive the line; it pulls the line low only in the ninth clock period, as the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw bus clock line as seen at the pad |
| sda_in | input | 1 | Raw bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low (open-drain enable) |
| regs_out | output | NREG*8 (128) | Register bank, register k in bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: sixteen registers, the count register at index 8 and a three-sample filter. With sixteen registers, a two-byte write or read that starts at index 15 reaches the wrap to 0. Each bus phase lasts eight system clocks, which is longer than the filter's latency, so clock and data edges reach the state machine in a known order. The bench also runs aborts by start and by stop part-way through a byte, a rejected address, a write longer than its count, and a host refusal during a read.

// File: rtl/smbr_pkg.sv
package smbr_pkg;

  // Transaction phases of the slave
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } smbr_state_e;

endpackage

// File: rtl/smbr_line_filter.sv
module smbr_line_filter #(
  parameter int LINES = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] filt,
  output logic [LINES-1:0] filt_q
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [1:0]       sync_q;
    logic [DEPTH-1:0] hist_q;
    logic             lvl_q, lvl_d, dly_q;

    // level moves only when the whole history agrees
    always_comb begin
      lvl_d = lvl_q;
      if (&hist_q)       lvl_d = 1'b1;
      else if (~|hist_q) lvl_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '1;
        hist_q <= '1;
        lvl_q  <= 1'b1;
        dly_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        hist_q <= {hist_q[DEPTH-2:0], sync_q[1]};
        lvl_q  <= lvl_d;
        dly_q  <= lvl_q;
      end
    end

    assign filt[g]   = lvl_q;
    assign filt_q[g] = dly_q;
  end

endmodule

// File: rtl/smbr_regbank.sv
module smbr_regbank #(
  parameter int          NREG    = 16,
  parameter int          CNT_IDX = 8,
  parameter logic [7:0]  CNT_RST = 8'h08,
  localparam int         AW      = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == CNT_IDX) ? CNT_RST : 8'h00;
    logic [7:0] q;
    logic       en;

    assign en = wr_en && (wr_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_V;
      else if (en) q <= wr_data;
    end

    assign regs_flat[g*8 +: 8] = q;
  end

  assign rd_data = regs_flat[rd_addr*8 +: 8];

endmodule

// File: rtl/smbr_blk_slave.sv
module smbr_blk_slave
  import smbr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h6E,
  parameter int         NREG       = 16,
  parameter int         CNT_IDX    = 8,
  parameter logic [7:0] CNT_RST    = 8'h08,
  parameter int         FILT_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_out
);

  localparam int AW = $clog2(NREG);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  // line conditioning and bus events
  logic [1:0] lvl, lvl_p;
  smbr_line_filter #(.LINES(2), .DEPTH(FILT_DEPTH)) u_filt (
    .clk(clk), .rst_n(rst_n_s), .raw({scl_in, sda_in}),
    .filt(lvl), .filt_q(lvl_p)
  );

  logic scl_f, scl_p, sda_f, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;
  assign {scl_f, sda_f} = lvl;
  assign {scl_p, sda_p} = lvl_p;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  // state
  smbr_state_e state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [6:0]    shr_q, shr_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    left_q, left_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          ack_q, ack_d;
  logic          oe_q, oe_d;

  logic       wr_en;
  logic [7:0] rx_byte, rd_data, cnt_val;
  logic       rx_phase;

  assign rx_byte  = {shr_q, sda_f};
  assign cnt_val  = regs_out[CNT_IDX*8 +: 8];
  assign rx_phase = (state_q == ST_ADDR) || (state_q == ST_INDEX) ||
                    (state_q == ST_COUNT) || (state_q == ST_WDATA);

  function automatic logic [AW-1:0] idx_next(input logic [AW-1:0] i);
    return (i == AW'(NREG-1)) ? '0 : i + 1'b1;
  endfunction

  smbr_regbank #(.NREG(NREG), .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST)) u_bank (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_addr(idx_q), .wr_data(rx_byte),
    .rd_addr(idx_q), .rd_data(rd_data), .regs_flat(regs_out)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    shr_d   = shr_q;
    tx_d    = tx_q;
    left_d  = left_q;
    idx_d   = idx_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (rx_phase) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          shr_d = rx_byte[6:0];
          bit_d = bit_q + 1'b1;
          if (bit_q == 4'd7) begin
            unique case (state_q)
              ST_ADDR:  ack_d = (rx_byte[7:1] == DEV_ADDR);
              ST_INDEX: begin ack_d = 1'b1; idx_d = rx_byte[AW-1:0]; end
              ST_COUNT: begin ack_d = 1'b1; left_d = rx_byte; end
              default: begin
                ack_d = (left_q != 8'd0);
                if (left_q != 8'd0) begin
                  wr_en  = 1'b1;
                  idx_d  = idx_next(idx_q);
                  left_d = left_q - 1'b1;
                end
              end
            endcase
          end
        end else if (bit_q == 4'd8) begin
          bit_d = 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_q == 4'd8) begin
          oe_d = ack_q;
          if (!ack_q) state_d = ST_IGNORE;
        end else if (bit_q == 4'd9) begin
          bit_d = '0;
          oe_d  = 1'b0;
          unique case (state_q)
            ST_ADDR: begin
              if (shr_q[0]) begin
                state_d = ST_RDATA;
                tx_d    = cnt_val;
                oe_d    = ~cnt_val[7];
              end else begin
                state_d = ST_INDEX;
              end
            end
            ST_INDEX: state_d = ST_COUNT;
            default:  state_d = ST_WDATA;
          endcase
        end
      end
    end else if (state_q == ST_RDATA) begin
      if (scl_rise) begin
        if (bit_q < 4'd8) begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[6:0], 1'b0};
        end else if (bit_q == 4'd8) begin
          ack_d = ~sda_f;
          bit_d = 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_q < 4'd8) begin
          oe_d = ~tx_q[7];
        end else if (bit_q == 4'd8) begin
          oe_d = 1'b0;
        end else begin
          bit_d = '0;
          if (ack_q) begin
            tx_d  = rd_data;
            idx_d = idx_next(idx_q);
            oe_d  = ~rd_data[7];
          end else begin
            state_d = ST_IGNORE;
            oe_d    = 1'b0;
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      shr_q   <= '0;
      tx_q    <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      shr_q   <= shr_d;
      tx_q    <= tx_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe = oe_q;

  // R9: drive changes only follow a low clock, except when a bus condition releases the line
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(oe_q) |-> (!$past(scl_f) || $past(start_det) || $past(stop_det)));

  // R9 / R2: while receiving, the line is pulled only around the acknowledge slot
  p_ack_slot_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_phase && oe_q) |-> (bit_q == 4'd8 || bit_q == 4'd9));

  // R4: a store at the top index wraps the pointer
  p_index_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && idx_q == AW'(NREG-1)) |=> (idx_q == '0));

  // R8: idle never drives the bus
  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IDLE) |-> !oe_q);

  // R6 / R1: the ignore phase never drives the bus
  p_ignore_release_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_IGNORE) |-> !oe_q);

  // R8: a stop always lands in idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop_det |=> (state_q == ST_IDLE));

endmodule

// File: tb/smbr_blk_slave_test.sv
`timescale 1ns/1ps
module smbr_blk_slave_test;

  localparam int NREG = 16;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_out;
  logic sda_bus;

  assign sda_bus = sda_drv & ~sda_oe;

  always #2 clk = ~clk;

  smbr_blk_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus),
    .sda_oe(sda_oe), .regs_out(regs_out)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model of the register bank
  logic [7:0] mreg [NREG];
  logic       cmp_en = 1'b0;
  string      cmp_tag = "R7";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison of the bank against the model in quiet windows
  always @(negedge clk) begin
    if (cmp_en) begin
      for (int k = 0; k < NREG; k++) begin
        checks++;
        if (regs_out[k*8 +: 8] !== mreg[k]) begin
          fails++;
          $display("FAIL %s reg%0d actual=%0h expected=%0h", cmp_tag, k,
                   regs_out[k*8 +: 8], mreg[k]);
        end
      end
    end
  end

  // R9: drive may change only while the raw clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev)) begin
      checks++;
      if (scl_drv !== 1'b0) begin
        fails++;
        $display("FAIL R9 drive change with clock high actual=%0h expected=%0h", scl_drv, 0);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic regs_check(input string tag);
    cmp_tag = tag;
    cmp_en = 1'b1;
    w(4);
    cmp_en = 1'b0;
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; w(Q);
    scl_drv = 1'b1; w(2*Q);
    sda_drv = 1'b0; w(2*Q);
    scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    w(Q); sda_drv = 1'b0; w(Q);
    scl_drv = 1'b1; w(2*Q);
    sda_drv = 1'b1; w(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      w(Q); sda_drv = b[i]; w(Q);
      scl_drv = 1'b1; w(Q);
      chk(sda_oe == 1'b0, "R9 data bit undriven", sda_oe, 0);
      w(Q);
      scl_drv = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    w(Q); sda_drv = 1'b1; w(Q);
    scl_drv = 1'b1; w(Q);
    acked = !sda_bus;
    w(Q);
    scl_drv = 1'b0;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_drv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(2*Q); scl_drv = 1'b1; w(Q);
      b[i] = sda_bus;
      w(Q); scl_drv = 1'b0;
    end
    w(Q); sda_drv = !ack; w(Q);
    scl_drv = 1'b1; w(2*Q);
    scl_drv = 1'b0; w(Q);
    sda_drv = 1'b1;
  endtask

  task automatic write_block(input logic [7:0] idx, input logic [7:0] data [$], input string tag);
    bit a;
    bus_start();
    send_byte(8'hDC, a); chk(a, {tag, " R1 write address ack"}, a, 1);
    send_byte(idx, a);   chk(a, {tag, " R2 index ack"}, a, 1);
    send_byte(8'(data.size()), a); chk(a, {tag, " R2 count ack"}, a, 1);
    foreach (data[k]) begin
      send_byte(data[k], a); chk(a, {tag, " R2 data ack"}, a, 1);
      mreg[(idx + k) % NREG] = data[k];
    end
    bus_stop();
  endtask

  // read: returns count byte and the register bytes; last one is refused
  task automatic read_block(input int idx, input int n, input string tag);
    bit a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hDC, a);   chk(a, {tag, " R1 write address ack"}, a, 1);
    send_byte(8'(idx), a); chk(a, {tag, " R2 index ack"}, a, 1);
    bus_start();
    send_byte(8'hDD, a);   chk(a, {tag, " R1 read address ack"}, a, 1);
    recv_byte(1'b1, v);    chk(v == mreg[8], {tag, " R5 count byte"}, v, mreg[8]);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk(v == mreg[(idx + k) % NREG], {tag, " R5 R4 read data"}, v, mreg[(idx + k) % NREG]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v;
    logic [7:0] d [$];
    for (int k = 0; k < NREG; k++) mreg[k] = (k == 8) ? 8'h08 : 8'h00;

    w(5); rst_n = 1'b1; w(40);

    // R7: reset state
    chk(sda_oe == 1'b0, "R7 line released after reset", sda_oe, 0);
    regs_check("R7");

    // R2: plain block write
    d = '{8'hA1, 8'hB2, 8'hC3};
    write_block(8'h02, d, "R2");
    regs_check("R2");

    // R3: byte past the count is refused and not stored
    bus_start();
    send_byte(8'hDC, a); chk(a, "R3 address ack", a, 1);
    send_byte(8'h05, a); chk(a, "R3 index ack", a, 1);
    send_byte(8'h01, a); chk(a, "R3 count ack", a, 1);
    send_byte(8'h5A, a); chk(a, "R3 counted byte ack", a, 1);
    mreg[5] = 8'h5A;
    send_byte(8'h77, a); chk(!a, "R3 extra byte refused", a, 0);
    send_byte(8'h99, a); chk(!a, "R3 bus ignored afterwards", a, 0);
    bus_stop();
    regs_check("R3");

    // R4: write wraps from 15 to 0
    d = '{8'hE1, 8'hE2};
    write_block(8'h0F, d, "R4");
    regs_check("R4");

    // program the count register
    d = '{8'h04};
    write_block(8'h08, d, "R5");
    regs_check("R5");

    // R5/R6: read from index 2, refuse the fourth byte
    read_block(2, 4, "R5");
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R6 nothing driven after refusal", v, 8'hFF);
    bus_stop();

    // R4/R5: read across the wrap
    read_block(15, 2, "R4");
    bus_stop();
    regs_check("R6");

    // R1: foreign address ignored until next start
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R1 foreign address refused", a, 0);
    send_byte(8'h03, a); chk(!a, "R1 following byte ignored", a, 0);
    send_byte(8'h01, a); chk(!a, "R1 following byte ignored", a, 0);
    send_byte(8'h42, a); chk(!a, "R1 following byte ignored", a, 0);
    bus_stop();
    regs_check("R1");

    // R8: stop part-way through a data byte
    bus_start();
    send_byte(8'hDC, a); chk(a, "R8 address ack", a, 1);
    send_byte(8'h03, a); chk(a, "R8 index ack", a, 1);
    send_byte(8'h02, a); chk(a, "R8 count ack", a, 1);
    send_bits(8'h3C, 4);
    bus_stop();
    regs_check("R8 stop abort");
    send_byte(8'hDC, a); chk(!a, "R8 idle refuses without start", a, 0);
    bus_stop();

    // R8: start part-way through a data byte restarts address reception
    bus_start();
    send_byte(8'hDC, a); chk(a, "R8 address ack", a, 1);
    send_byte(8'h06, a); chk(a, "R8 index ack", a, 1);
    send_byte(8'h01, a); chk(a, "R8 count ack", a, 1);
    send_bits(8'h11, 3);
    bus_start();
    send_byte(8'hDC, a); chk(a, "R8 address after restart", a, 1);
    send_byte(8'h06, a); chk(a, "R8 index after restart", a, 1);
    send_byte(8'h01, a); chk(a, "R8 count after restart", a, 1);
    send_byte(8'h66, a); chk(a, "R8 data after restart", a, 1);
    mreg[6] = 8'h66;
    bus_stop();
    regs_check("R8 start abort");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule